// File: doc/BRIEF.md
# Data-Switch Control Output Generator

This block produces the control for an active-low, three-state pin that closes an external data isolation switch while a memory device moves burst data. It watches decoded read commands, decoded write commands and a one-cycle pulse for every falling edge of the incoming write strobe. It drives the pin low around each transfer and otherwise leaves it floating. The read latency and the burst length come from its own copy of the ordinary mode register. A single enable bit, held in the extended mode register, turns the whole function on or off.

For a read, the drive window opens with the read strobe preamble and closes once the postamble has ended. Both edges are rounded outward to whole clock cycles, so the window never falls short of the strobe activity. For a write, the pin is driven from the command edge onward. It is released once the expected number of strobe falling edges has arrived, which is half the burst length. Commands that follow one another while a window is still open extend that window with no floating gap.

The output `sw_drive_o` is the three-state enable for the pin. When it is 1 the pin is driven low, and when it is 0 the pin is high impedance. "Cycle n" below means the clock period that begins at the n-th rising edge after the edge that captured the command, so the capturing edge itself is edge 0. L is the read latency in half cycles (4, 5 or 6 for 2, 2.5 or 3 cycles), and BL is the burst length in beats.

Top module: `iso_switch_ctl`

## Requirements
- R1: After a synchronous reset, `sw_drive_o` is 0, the enable is clear, the burst length is 2 and the read latency is 2 cycles.
- R2: A mode write with `mrs_ext_i`=1 copies `mode_addr_i[2]` into the enable. While the enable is clear, `sw_drive_o` stays 0. Read and write commands captured while the enable is clear leave no pending window behind once the enable is set again.
- R3: A mode write with `mrs_ext_i`=0 decodes the burst length from `mode_addr_i[2:0]` (001=2, 010=4, 011=8) and the read latency from `mode_addr_i[6:4]` (010=2, 110=2.5, 011=3 cycles). Any other code leaves that field unchanged. An extended write changes neither field.
- R4: A read captured while no read window is open or pending starts driving in cycle (L-2)/2, rounded down. That is cycle 1 for latencies 2 and 2.5, and cycle 2 for latency 3. Cycle 0 is not driven by that read.
- R5: The last cycle a read drives is (L+BL)/2, rounded down. Cycle (L+BL)/2+1 is released unless another window covers it.
- R6: A write drives the pin from cycle 0 onward.
- R7: Each write adds BL/2 expected strobe falling pulses. The pin is released in the cycle of the pulse that brings the outstanding count to zero. A pulse that arrives while no write is outstanding has no effect.
- R8: A read captured while an earlier read window is pending or covered the previous cycle keeps the original start and moves the end to the new read's last cycle, with no released cycle in between.
- R9: A write captured while pulses are still outstanding adds its BL/2 to the outstanding count, so the pin stays driven until all of them have arrived.
- R10: The pin is driven in any cycle covered by a read window or by an outstanding write, provided the enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mrs_i | input | 1 | Decoded mode-register write command |
| mrs_ext_i | input | 1 | Bank bit 0 of that command: 1 selects the extended register |
| mode_addr_i | input | 7 | Address bits 6..0 carried with the mode write |
| rd_cmd_i | input | 1 | Decoded read command (one cycle) |
| wr_cmd_i | input | 1 | Decoded write command (one cycle) |
| wr_fall_i | input | 1 | One-cycle pulse per falling edge of the incoming write strobe |
| sw_drive_o | output | 1 | 1: drive the switch pin low; 0: leave it high impedance |

## Verification
The hardest situations to reach from the ports are overlaps that land exactly on a window boundary. Examples are a read captured on the edge where the previous window would have closed, a write captured on the same edge as a strobe pulse, and a read arriving while a latency-3 start is still pending. Directed sequences place these deliberately. Long constrained-random runs then mix reads, writes, stray strobe pulses and mode rewrites with legal and reserved codes. Every cycle is compared with a window model held in absolute cycle numbers.

// File: rtl/iso_switch_pkg.sv
package iso_switch_pkg;
  localparam int LAT_W = 3;   // read latency in half cycles (4..6)
  localparam int BL_W  = 4;   // burst length in beats (2..8)

  typedef logic [LAT_W-1:0] lat_t;
  typedef logic [BL_W-1:0]  bl_t;

  localparam lat_t LAT_RST = lat_t'(4);
  localparam bl_t  BL_RST  = bl_t'(2);

  // zero marks a reserved code
  function automatic bl_t decode_bl(input logic [2:0] code);
    case (code)
      3'b001:  return bl_t'(2);
      3'b010:  return bl_t'(4);
      3'b011:  return bl_t'(8);
      default: return '0;
    endcase
  endfunction

  function automatic lat_t decode_lat(input logic [2:0] code);
    case (code)
      3'b010:  return lat_t'(4);
      3'b110:  return lat_t'(5);
      3'b011:  return lat_t'(6);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/iso_mode_regs.sv
module iso_mode_regs
  import iso_switch_pkg::*;
#(
  parameter int MW      = 7,
  parameter int EN_BIT  = 2,
  parameter int BL_LSB  = 0,
  parameter int LAT_LSB = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          mrs_i,
  input  logic          ext_i,
  input  logic [MW-1:0] addr_i,
  output logic          en_o,
  output lat_t          lat_o,
  output bl_t           bl_o
);
  bl_t  bl_dec;
  lat_t lat_dec;
  logic unused_addr;

  assign bl_dec      = decode_bl(addr_i[BL_LSB +: 3]);
  assign lat_dec     = decode_lat(addr_i[LAT_LSB +: 3]);
  assign unused_addr = ^addr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_o  <= 1'b0;
      lat_o <= LAT_RST;
      bl_o  <= BL_RST;
    end else if (mrs_i) begin
      if (ext_i) begin
        en_o <= addr_i[EN_BIT];
      end else begin
        if (bl_dec != '0)  bl_o  <= bl_dec;
        if (lat_dec != '0) lat_o <= lat_dec;
      end
    end
  end

  // R3: only legal field values are ever held
  a_r3_legal_fields: assert property (@(posedge clk_i) disable iff (rst_i)
    (lat_o inside {lat_t'(4), lat_t'(5), lat_t'(6)}) &&
    (bl_o inside {bl_t'(2), bl_t'(4), bl_t'(8)}));

  // R2: extended write loads enable and leaves the mode fields alone
  a_r2_ext_write: assert property (@(posedge clk_i) disable iff (rst_i)
    (mrs_i && ext_i) |=> (en_o == $past(addr_i[EN_BIT])) &&
                         $stable(lat_o) && $stable(bl_o));
endmodule

// File: rtl/iso_rd_window.sv
module iso_rd_window
  import iso_switch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic cmd_i,
  input  lat_t lat_i,
  input  bl_t  bl_i,
  output logic rd_on_o
);
  localparam int CNT_W = BL_W;

  logic [CNT_W:0]   lat_x, sum_x, lat_m2;
  logic [CNT_W-1:0] start_d, stop_d;
  logic [CNT_W-1:0] ton, toff;
  logic             pending;

  assign lat_x   = (CNT_W+1)'(lat_i);
  assign sum_x   = lat_x + (CNT_W+1)'(bl_i);
  assign lat_m2  = lat_x - (CNT_W+1)'(2);
  assign start_d = CNT_W'(lat_m2 >> 1);
  assign stop_d  = CNT_W'(sum_x >> 1);
  assign pending = (ton != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ton     <= '0;
      toff    <= '0;
      rd_on_o <= 1'b0;
    end else begin
      // start countdown: only a read into an idle window arms it
      if (pending)                          ton <= ton - 1'b1;
      else if (cmd_i && !rd_on_o)           ton <= start_d;

      // stop countdown: every read re-targets the end of the window
      if (cmd_i)                            toff <= stop_d;
      else if ((pending || rd_on_o) && toff != '0) toff <= toff - 1'b1;

      if (pending && ton == CNT_W'(1))      rd_on_o <= 1'b1;
      else if (rd_on_o && !cmd_i && toff == '0) rd_on_o <= 1'b0;
    end
  end

  // R4: a read into an idle window never drives its capture cycle
  a_r4_late_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i && !rd_on_o && !pending) |=> !rd_on_o);

  // R8: a read during an open window leaves no gap
  a_r8_no_gap: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i && rd_on_o) |=> rd_on_o);

  // R5: an expired window closes
  a_r5_release: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_on_o && !cmd_i && toff == '0) |=> !rd_on_o);
endmodule

// File: rtl/iso_wr_track.sv
module iso_wr_track
  import iso_switch_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cmd_i,
  input  logic fall_i,
  input  bl_t  bl_i,
  output logic wr_on_o
);
  localparam logic [CW:0] REM_MAX = (CW+1)'((1 << CW) - 1);

  logic [CW-1:0] rem, add, dec;

  assign add     = cmd_i ? CW'(bl_i >> 1) : '0;
  assign dec     = (fall_i && rem != '0) ? CW'(1) : '0;
  assign wr_on_o = (rem != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) rem <= '0;
    else       rem <= rem - dec + add;
  end

  // R6: a write opens the window at once
  a_r6_drive: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_i |=> wr_on_o);

  // R7: strobe pulses with nothing outstanding are ignored
  a_r7_stray_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_on_o && !cmd_i) |=> !wr_on_o);

  // R9: stacked writes must fit in the outstanding counter
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_i |-> ((CW+1)'(rem) + (CW+1)'(add)) <= REM_MAX);
endmodule

// File: rtl/iso_switch_ctl.sv
module iso_switch_ctl
  import iso_switch_pkg::*;
#(
  parameter int MW      = 7,
  parameter int EN_BIT  = 2,
  parameter int BL_LSB  = 0,
  parameter int LAT_LSB = 4,
  parameter int CW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          mrs_i,
  input  logic          mrs_ext_i,
  input  logic [MW-1:0] mode_addr_i,
  input  logic          rd_cmd_i,
  input  logic          wr_cmd_i,
  input  logic          wr_fall_i,
  output logic          sw_drive_o
);
  logic en, rd_on, wr_on;
  lat_t lat;
  bl_t  bl;

  iso_mode_regs #(.MW(MW), .EN_BIT(EN_BIT), .BL_LSB(BL_LSB), .LAT_LSB(LAT_LSB)) u_mode (
    .clk_i(clk_i), .rst_i(rst_i), .mrs_i(mrs_i), .ext_i(mrs_ext_i),
    .addr_i(mode_addr_i), .en_o(en), .lat_o(lat), .bl_o(bl)
  );

  iso_rd_window u_rd (
    .clk_i(clk_i), .rst_i(rst_i), .cmd_i(rd_cmd_i & en),
    .lat_i(lat), .bl_i(bl), .rd_on_o(rd_on)
  );

  iso_wr_track #(.CW(CW)) u_wr (
    .clk_i(clk_i), .rst_i(rst_i), .cmd_i(wr_cmd_i & en),
    .fall_i(wr_fall_i), .bl_i(bl), .wr_on_o(wr_on)
  );

  assign sw_drive_o = en & (rd_on | wr_on);
endmodule

// File: tb/sim_iso_switch_ctl.sv
`timescale 1ns/1ps
module sim_iso_switch_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mrs = 1'b0, ext = 1'b0, rd = 1'b0, wr = 1'b0, fall = 1'b0;
  logic [6:0] addr = '0;
  logic       drive;

  int vecs = 0, errs = 0, cyc = 0;
  int m_en, m_lat, m_bl, m_rs, m_re, m_rv, m_rem;

  always #2 clk = ~clk;

  iso_switch_ctl u0 (
    .clk_i(clk), .rst_i(rst), .mrs_i(mrs), .mrs_ext_i(ext), .mode_addr_i(addr),
    .rd_cmd_i(rd), .wr_cmd_i(wr), .wr_fall_i(fall), .sw_drive_o(drive)
  );

  function automatic int dec_bl(input logic [2:0] c, input int old);
    case (c) 3'b001: return 2; 3'b010: return 4; 3'b011: return 8; default: return old; endcase
  endfunction
  function automatic int dec_lat(input logic [2:0] c, input int old);
    case (c) 3'b010: return 4; 3'b110: return 5; 3'b011: return 6; default: return old; endcase
  endfunction
  function automatic logic exp_drive(input int t);
    return (m_en != 0) && ((m_rv != 0 && m_rs <= t && t <= m_re) || m_rem > 0);
  endfunction

  task automatic model_edge();
    int old_en = m_en;
    if (rst) begin
      m_en = 0; m_lat = 4; m_bl = 2; m_rv = 0; m_rs = 0; m_re = -10; m_rem = 0;
      return;
    end
    if (mrs) begin
      if (ext) m_en = addr[2];
      else begin m_bl = dec_bl(addr[2:0], m_bl); m_lat = dec_lat(addr[6:4], m_lat); end
    end
    if (old_en != 0 && rd) begin
      if (m_rv != 0 && cyc - 1 <= m_re) m_re = cyc + (m_lat + m_bl) / 2;
      else begin m_rv = 1; m_rs = cyc + (m_lat - 2) / 2; m_re = cyc + (m_lat + m_bl) / 2; end
    end
    if (fall && m_rem > 0) m_rem--;
    if (old_en != 0 && wr) m_rem += m_bl / 2;
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vecs++;
    if (drive !== exp_drive(cyc)) begin
      errs++;
      $display("FAIL %s cycle %0d: sw_drive_o=%0b expected %0b", req, cyc, drive, exp_drive(cyc));
    end
    cyc++;
    mrs = 0; ext = 0; rd = 0; wr = 0; fall = 0; addr = '0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask
  task automatic mode_wr(input logic e, input logic [6:0] a, input string req);
    mrs = 1; ext = e; addr = a; tick(req);
  endtask
  task automatic cmd(input logic r, input logic w, input logic f, input string req);
    rd = r; wr = w; fall = f; tick(req);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL R10 watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd2024));
    idle(3, "R1");                         // reset state
    rst = 0;
    idle(2, "R1");
    cmd(1, 1, 0, "R2"); idle(6, "R2");     // disabled: nothing happens
    mode_wr(1, 7'h04, "R2");               // enable
    cmd(1, 0, 0, "R4"); idle(5, "R5");     // CL2 BL2: cycles 1..3
    mode_wr(0, 7'h33, "R3");               // CL3, BL8
    cmd(1, 0, 0, "R4"); idle(9, "R5");     // cycles 2..7
    mode_wr(0, 7'h70, "R3");               // reserved codes: no change
    cmd(1, 0, 0, "R3"); idle(9, "R3");
    mode_wr(1, 7'h7B, "R3");               // ext write with bit2=0 disables, fields kept
    mode_wr(1, 7'h04, "R2");
    cmd(1, 0, 0, "R3"); idle(9, "R3");     // still CL3/BL8
    mode_wr(0, 7'h62, "R3");               // CL2.5, BL4
    cmd(1, 0, 0, "R5"); idle(6, "R5");     // cycles 1..4
    cmd(0, 1, 0, "R6"); idle(1, "R6");
    cmd(0, 0, 1, "R7"); cmd(0, 0, 1, "R7"); idle(2, "R7");
    cmd(0, 0, 1, "R7"); cmd(0, 0, 1, "R7"); idle(2, "R7");   // stray pulses
    cmd(0, 1, 1, "R7"); idle(1, "R7");     // stray pulse on the write edge
    cmd(0, 0, 1, "R7"); cmd(0, 0, 1, "R7"); idle(2, "R7");
    cmd(1, 0, 0, "R8"); idle(1, "R8"); cmd(1, 0, 0, "R8"); idle(7, "R8");
    cmd(1, 0, 0, "R8"); idle(3, "R8"); cmd(1, 0, 0, "R8"); idle(7, "R8"); // edge of close
    mode_wr(0, 7'h33, "R8");
    cmd(1, 0, 0, "R8"); cmd(1, 0, 0, "R8"); idle(9, "R8");   // read during pending start
    mode_wr(0, 7'h22, "R9");               // CL2, BL4
    cmd(0, 1, 0, "R9"); cmd(0, 0, 1, "R9"); cmd(0, 1, 1, "R9");
    cmd(0, 0, 1, "R9"); cmd(0, 0, 1, "R9"); idle(2, "R9");
    cmd(1, 1, 0, "R10"); idle(2, "R10"); cmd(0, 0, 1, "R10"); cmd(0, 0, 1, "R10"); idle(4, "R10");
    cmd(0, 1, 0, "R2"); mode_wr(1, 7'h00, "R2");              // disable mid-write
    cmd(1, 1, 0, "R2"); idle(2, "R2"); cmd(0, 0, 1, "R2"); cmd(0, 0, 1, "R2");
    mode_wr(1, 7'h04, "R2"); idle(8, "R2");
    for (int n = 0; n < 6000; n++) begin
      r = $urandom_range(0, 99);
      if (r < 3) begin
        mrs = 1; ext = ($urandom_range(0, 3) == 0);
        addr = ext ? (($urandom_range(0, 9) == 0) ? 7'h00 : 7'h04) : 7'($urandom_range(0, 127));
      end else begin
        rd = ($urandom_range(0, 5) == 0);
        wr = ($urandom_range(0, 6) == 0) && (m_rem <= 7);
        fall = ($urandom_range(0, 2) == 0);
      end
      tick("R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule